// File: doc/BRIEF.md
# Multicycle Instruction Sequencer with Datapath

This block executes a small 32-bit load/store instruction subset one step per clock. It covers register-to-register arithmetic, word load, word store, branch-on-equal and an absolute jump. Every instruction starts with a fetch step and a decode step. The remaining steps depend on the instruction class, and then control returns to fetch. The block contains a program counter, an instruction register, two operand latches, a result latch, a memory data latch and a 32-entry register file.

All instruction and data traffic uses one shared memory port. The port has no handshake: the block drives an address with a read or a write strobe. Read data must be valid on `mem_rdata` in the same cycle and is captured at the next rising edge. A write strobe commits at that edge. This suits a plain behavioural or single-cycle memory.

The decode step always computes the branch target, before the class of the instruction is known. The execute step of a branch reuses that value, so no second address adder is needed on the branch path.

Top module: `mcs_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC is set to 0 and the step to fetch. The first fetch after reset therefore reads address 0 with `mem_rd` high and `mem_wr` low.
- R2: `step_o` encodes the steps as fetch=0, decode=1, execute=2, memory/writeback=3, load-completion=4. In fetch, the instruction register captures the memory word at the PC and the PC advances by 4 in that same step. Decode always follows fetch.
- R3: Decode latches operand A from register IR[25:21] and operand B from register IR[20:16]. In the same step it stores PC + (sign-extended IR[15:0] << 2) as a branch target, for every instruction. Execute always follows decode.
- R4: Opcode IR[31:26]=0x00 is register-to-register. Function code IR[5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than. The result is written to register IR[15:11] in the fourth step, and the instruction takes 4 cycles.
- R5: Opcode 0x23 loads the word at A + sign-extended IR[15:0] into register IR[20:16]. It takes 5 cycles: the memory read is latched in step four and written to the register in step five.
- R6: Opcode 0x2B writes B to memory at A + sign-extended IR[15:0] in step four and takes 4 cycles. `mem_wr` is never high in any other situation.
- R7: Opcode 0x04 takes 3 cycles. If A equals B, the PC is loaded with the target computed in decode; negative offsets branch backwards. Otherwise the PC keeps the fetch increment.
- R8: Opcode 0x02 takes 3 cycles and loads the PC with the top four bits of the incremented PC, followed by IR[25:0] and two zero bits.
- R9: Register 0 always reads as zero. A write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address of the memory access |
| mem_rd | output | 1 | Read strobe, data expected on mem_rdata in the same cycle |
| mem_wr | output | 1 | Write strobe, commits mem_wdata at the clock edge |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data from memory |
| step_o | output | 3 | Current step of the sequencer |

## Verification
The hardest case to observe from the ports is a taken branch. The evidence is an instruction that never runs, and the branch itself leaves no trace in memory. The test program sets up a backward branch and a forward branch. Every skipped path is filled with stores aimed at words preloaded with a marker pattern, so any instruction that runs when it should not overwrites a marker. The program ends in a branch to itself with a negative offset. Per-class cycle counts are taken from the gaps between consecutive fetch steps seen on `step_o` and `mem_addr`.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int RIDX  = $clog2(NREGS);

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_LDWB   = 3'd4
  } step_e;

  typedef enum logic [1:0] {PCS_INC, PCS_TGT, PCS_JMP} pc_src_e;
  typedef enum logic [1:0] {OS_BRT, OS_FUNC, OS_EA} out_src_e;

  localparam logic [5:0] OPC_REG = 6'h00;
  localparam logic [5:0] OPC_LW  = 6'h23;
  localparam logic [5:0] OPC_SW  = 6'h2B;
  localparam logic [5:0] OPC_BEQ = 6'h04;
  localparam logic [5:0] OPC_JMP = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic     mem_rd;
    logic     mem_wr;
    logic     addr_out;
    logic     ir_ld;
    logic     ab_ld;
    logic     mdr_ld;
    logic     out_ld;
    logic     rf_we;
    logic     rf_from_mdr;
    logic     pc_ld;
    pc_src_e  pc_src;
    out_src_e out_src;
  } ctl_t;
endpackage

// File: rtl/mcs_regfile.sv
module mcs_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [DEPTH];

  // entry 0 is never stored; reads of it are forced to zero
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/mcs_alu.sv
module mcs_alu
  import mcs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [5:0]   fn,
  input  logic         use_fn,
  output logic [W-1:0] y
);
  always_comb begin
    y = a + b;
    if (use_fn) begin
      unique case (fn)
        FN_ADD:  y = a + b;
        FN_SUB:  y = a - b;
        FN_AND:  y = a & b;
        FN_OR:   y = a | b;
        FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        default: y = '0;
      endcase
    end
  end
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic       a_eq_b,
  output step_e      step,
  output ctl_t       ctl
);
  step_e step_n;

  always_ff @(posedge clk) begin
    if (rst) step <= ST_FETCH;
    else     step <= step_n;
  end

  always_comb begin
    ctl    = '0;
    step_n = ST_FETCH;
    unique case (step)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_ld  = 1'b1;
        ctl.pc_ld  = 1'b1;
        ctl.pc_src = PCS_INC;
        step_n     = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.ab_ld   = 1'b1;
        ctl.out_ld  = 1'b1;
        ctl.out_src = OS_BRT;
        step_n      = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (opcode)
          OPC_REG: begin
            ctl.out_ld  = 1'b1;
            ctl.out_src = OS_FUNC;
            step_n      = ST_MEM;
          end
          OPC_LW, OPC_SW: begin
            ctl.out_ld  = 1'b1;
            ctl.out_src = OS_EA;
            step_n      = ST_MEM;
          end
          OPC_BEQ: begin
            ctl.pc_ld  = a_eq_b;
            ctl.pc_src = PCS_TGT;
          end
          OPC_JMP: begin
            ctl.pc_ld  = 1'b1;
            ctl.pc_src = PCS_JMP;
          end
          default: ;
        endcase
      end
      ST_MEM: begin
        unique case (opcode)
          OPC_REG: ctl.rf_we = 1'b1;
          OPC_SW: begin
            ctl.mem_wr   = 1'b1;
            ctl.addr_out = 1'b1;
          end
          OPC_LW: begin
            ctl.mem_rd   = 1'b1;
            ctl.addr_out = 1'b1;
            ctl.mdr_ld   = 1'b1;
            step_n       = ST_LDWB;
          end
          default: ;
        endcase
      end
      ST_LDWB: begin
        ctl.rf_we       = 1'b1;
        ctl.rf_from_mdr = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcs_core.sv
module mcs_core
  import mcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [2:0]      step_o
);
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, out_q, mdr_q;
  logic [XLEN-1:0] rf_qa, rf_qb, imm_sx, br_tgt, alu_y, out_d, pc_d, rf_wd;
  logic [RIDX-1:0] rf_wa;
  step_e           step;
  ctl_t            ctl;

  assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign br_tgt = pc_q + {imm_sx[XLEN-3:0], 2'b00};

  mcs_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_q[31:26]),
    .a_eq_b (a_q == b_q),
    .step   (step),
    .ctl    (ctl)
  );

  assign rf_wa = ctl.rf_from_mdr ? ir_q[20:16] : ir_q[15:11];
  assign rf_wd = ctl.rf_from_mdr ? mdr_q : out_q;

  mcs_regfile #(.W(XLEN), .DEPTH(NREGS)) u_rf (
    .clk (clk),
    .ra  (ir_q[25:21]),
    .rb  (ir_q[20:16]),
    .qa  (rf_qa),
    .qb  (rf_qb),
    .we  (ctl.rf_we),
    .wa  (rf_wa),
    .wd  (rf_wd)
  );

  mcs_alu #(.W(XLEN)) u_alu (
    .a      (a_q),
    .b      ((ctl.out_src == OS_FUNC) ? b_q : imm_sx),
    .fn     (ir_q[5:0]),
    .use_fn (ctl.out_src == OS_FUNC),
    .y      (alu_y)
  );

  always_comb begin
    unique case (ctl.out_src)
      OS_BRT:  out_d = br_tgt;
      default: out_d = alu_y;
    endcase
    unique case (ctl.pc_src)
      PCS_TGT: pc_d = out_q;
      PCS_JMP: pc_d = {pc_q[31:28], ir_q[25:0], 2'b00};
      default: pc_d = pc_q + 32'd4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (ctl.pc_ld) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.ir_ld)  ir_q  <= mem_rdata;
    if (ctl.mdr_ld) mdr_q <= mem_rdata;
    if (ctl.out_ld) out_q <= out_d;
    if (ctl.ab_ld) begin
      a_q <= rf_qa;
      b_q <= rf_qb;
    end
  end

  assign mem_addr  = ctl.addr_out ? out_q : pc_q;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign mem_wdata = b_q;
  assign step_o    = step;
endmodule

// File: rtl/mcs_core_chk.sv
module mcs_core_chk
  import mcs_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [2:0]      step,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] ir,
  input logic [XLEN-1:0] a,
  input logic [XLEN-1:0] b,
  input logic            mem_rd,
  input logic            mem_wr
);
  AST_FETCH_READS: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH) |-> (mem_rd && !mem_wr)); // R1

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH) |=> (pc == $past(pc) + 32'd4)); // R2

  AST_DECODE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH) |=> (step == ST_DECODE)); // R2

  AST_EXEC_NEXT: assert property (@(posedge clk) disable iff (rst)
    (step == ST_DECODE) |=> (step == ST_EXEC)); // R3

  AST_LDWB_AFTER_MEM: assert property (@(posedge clk) disable iff (rst)
    (step == ST_LDWB) |-> ($past(step) == ST_MEM && ir[31:26] == OPC_LW)); // R5

  AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (step == ST_MEM && ir[31:26] == OPC_SW)); // R6

  AST_BEQ_UNTAKEN: assert property (@(posedge clk) disable iff (rst)
    (step == ST_EXEC && ir[31:26] == OPC_BEQ && a != b) |=> (pc == $past(pc))); // R7

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (step == ST_EXEC && ir[31:26] == OPC_JMP)
      |=> (pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00})); // R8

  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step == ST_DECODE && ir[25:21] == '0) |=> (a == '0)); // R9
endmodule

bind mcs_core mcs_core_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .step   (step_o),
  .pc     (pc_q),
  .ir     (ir_q),
  .a      (a_q),
  .b      (b_q),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr)
);

// File: tb/mcs_core_tb.sv
module mcs_core_tb;
  localparam int NPROG = 27;
  localparam int NCHK  = 11;
  localparam logic [31:0] MARK = 32'hDEADBEEF;

  localparam logic [31:0] PROG [NPROG] = '{
    32'h8C010200, 32'h8C020204, 32'h00221820, 32'h00222022, 32'h00222824,
    32'h00223025, 32'h0041382A, 32'h00414022, 32'h0100482A, 32'h00220020,
    32'h10220005, 32'h10260002, 32'hAC0102F0, 32'hAC0102F4, 32'h08000012,
    32'hAC0102F8, 32'h00000000, 32'h00000000, 32'hAC030300, 32'hAC040304,
    32'hAC050308, 32'hAC06030C, 32'hAC070310, 32'hAC080314, 32'hAC090318,
    32'hAC00031C, 32'h1000FFFF
  };

  // result word address and expected content, walked by one loop
  localparam logic [31:0] CHK_ADDR [NCHK] = '{
    32'h300, 32'h304, 32'h308, 32'h30C, 32'h310, 32'h314, 32'h318,
    32'h31C, 32'h2F0, 32'h2F4, 32'h2F8
  };
  localparam logic [31:0] CHK_VAL [NCHK] = '{
    32'd12, 32'd2, 32'd5, 32'd7, 32'd1, 32'hFFFFFFFE, 32'd1,
    32'd0, MARK, MARK, MARK
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;
  logic [2:0]  step_o;
  logic [31:0] mem [256];
  int          fetch_t [64];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  mcs_core u_dut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .step_o    (step_o)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (!rst && step_o == 3'd0 && mem_addr[31:8] == '0 && fetch_t[mem_addr[7:2]] < 0)
      fetch_t[mem_addr[7:2]] = cyc;
  end

  function automatic string row_req(int i);
    case (i)
      7:       return "R9";
      8:       return "R7";
      9:       return "R3";
      10:      return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = MARK;
    for (int i = 0; i < NPROG; i++) mem[i] = PROG[i];
    mem[128] = 32'd7;
    mem[129] = 32'd5;
    for (int i = 0; i < 64; i++) fetch_t[i] = -1;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset step", {29'd0, step_o}, 32'd0);
    chk("R1", "reset fetch address", mem_addr, 32'd0);
    chk("R1", "reset strobes", {30'd0, mem_rd, mem_wr}, 32'd2);
    rst = 1'b0;

    repeat (300) @(posedge clk);
    @(negedge clk);

    for (int i = 0; i < NCHK; i++)
      chk(row_req(i), "memory word", mem[CHK_ADDR[i][9:2]], CHK_VAL[i]);

    chk("R2", "second fetch seen", {31'd0, fetch_t[1] >= 0}, 32'd1);
    chk("R5", "load cycles", fetch_t[1] - fetch_t[0], 32'd5);
    chk("R4", "register op cycles", fetch_t[3] - fetch_t[2], 32'd4);
    chk("R7", "untaken branch cycles", fetch_t[11] - fetch_t[10], 32'd3);
    chk("R7", "taken branch cycles", fetch_t[14] - fetch_t[11], 32'd3);
    chk("R8", "jump cycles", fetch_t[18] - fetch_t[14], 32'd3);
    chk("R6", "store cycles", fetch_t[19] - fetch_t[18], 32'd4);
    chk("R7", "backward loop holds", {31'd0, fetch_t[27] < 0}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule